// File: doc/BRIEF.md
# DRAM Controller Operating-Mode Sequencer

This block is the top-level mode sequencer of a DRAM controller. Software writes a command code into a control register. The sequencer then moves between four stable modes: memory init, configuration, normal access and low power (self-refresh). Every move into configuration, access or low power passes through a visible request state. A 3-bit status field reports which state the sequencer is in, including the request states, so software can poll for completion.

Each request state raises one handshake output toward the command path or the PHY. The state is held until the acknowledge input is seen. Leaving low power also waits for the PHY DLL-lock indication, so access is only reported once the clocks are stable. Low power can also be entered on a hardware request. In that case a status field marks the trigger, and only the hardware request can end that low-power stay.

DRAM command generation and timing counters lie outside this block. They are represented here only by the acknowledge and lock inputs.

Top module: `mc_mode_seq`

## Requirements
- R1: After reset the status field reads 0 (init_mem), the trigger field reads 0, `access_ok_o` is low and the control register reads 0.
- R2: Register address 0 is the control register. A write there stores the whole data word, and that word reads back unchanged; bits [2:0] of the written word are the command: 0 init, 1 config, 2 go, 3 sleep, 4 wakeup, 5 to 7 unused. Address 1 is the status register: bits [2:0] hold the state (0 init_mem, 1 config, 2 config_req, 3 access, 4 access_req, 5 low_power, 6 low_power_entry_req, 7 low_power_exit_req), bits [6:4] hold the trigger source (0 software, 1 hardware), and all other bits read 0.
- R3: A config command in init_mem or access moves the sequencer to config_req, and then to config once `cmd_ack_i` is seen. Config_req is entered from no other state, and `quiesce_req_o` is high only in config_req.
- R4: A go command in config moves the sequencer to access_req, and then to access once acknowledged. `resume_req_o` is high in access_req, and `access_ok_o` is high only in access.
- R5: Every request state lasts at least one cycle, even when `cmd_ack_i` is already high on entry, and it holds for as long as the acknowledge needed to leave it is absent. At most one handshake output is high at a time.
- R6: A sleep command in access moves the sequencer to low_power_entry_req with trigger 0, and then to low_power once acknowledged. `sr_entry_req_o` is high in low_power_entry_req.
- R7: With `hw_lp_req_i` high in access and no legal command written in that cycle, the sequencer enters low_power_entry_req and then low_power with trigger 1. When `hw_lp_req_i` falls in low_power, the sequencer moves to low_power_exit_req.
- R8: A wakeup command in low_power with trigger 0 moves the sequencer to low_power_exit_req (`sr_exit_req_o` high) and from there always to access, never to config. The trigger field returns to 0 on entry to access.
- R9: Low_power_exit_req is left only in a cycle where both `cmd_ack_i` and `phy_dll_lock_i` are high.
- R10: In low_power with trigger 1, a wakeup command is ignored while `hw_lp_req_i` stays high.
- R11: A command that is not legal in the current state is ignored and the status does not change. This covers codes 5 to 7, go in init_mem, sleep in config, config in low_power, and any command in a request state.
- R12: An init command in config returns the sequencer directly to init_mem. Init_mem is entered from no other state.
- R13: Writes to the status address change neither the state nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| cmd_ack_i | input | 1 | Acknowledge from command path / PHY for the current request state |
| phy_dll_lock_i | input | 1 | PHY DLL locked |
| hw_lp_req_i | input | 1 | Hardware low-power request |
| quiesce_req_o | output | 1 | Request to quiesce traffic for configuration |
| resume_req_o | output | 1 | Request to resume normal access |
| sr_entry_req_o | output | 1 | Request for self-refresh entry |
| sr_exit_req_o | output | 1 | Request for self-refresh exit |
| access_ok_o | output | 1 | Memory usable for normal access |

## Verification
The assertions check the following on every cycle: request states hold while the acknowledge is absent, low-power exit always lands in access and only once the DLL is locked, config_req and init_mem are entered only from their legal predecessors, a hardware-triggered low-power stay ignores wakeup, and the handshake outputs are mutually exclusive. Only the bench scenarios show the full command table: all eight codes are swept from each stable mode, and the resulting status codes and readback values are compared against a model of the requirements. The bench scenarios also cover the hardware-trigger round trip, and status-register writes that must have no effect.

// File: rtl/mc_mode_pkg.sv
package mc_mode_pkg;
  localparam int CMD_W  = 3;
  localparam int STAT_W = 3;
  localparam int TRIG_W = 3;
  localparam int TRIG_LSB = 4;

  typedef enum logic [STAT_W-1:0] {
    ST_INIT    = 3'd0,
    ST_CFG     = 3'd1,
    ST_CFG_REQ = 3'd2,
    ST_ACC     = 3'd3,
    ST_ACC_REQ = 3'd4,
    ST_LP      = 3'd5,
    ST_LPE_REQ = 3'd6,
    ST_LPX_REQ = 3'd7
  } mode_e;

  localparam logic [CMD_W-1:0] CMD_INIT  = 3'd0;
  localparam logic [CMD_W-1:0] CMD_CFG   = 3'd1;
  localparam logic [CMD_W-1:0] CMD_GO    = 3'd2;
  localparam logic [CMD_W-1:0] CMD_SLEEP = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WAKE  = 3'd4;

  localparam logic [TRIG_W-1:0] TRIG_SW = 3'd0;
  localparam logic [TRIG_W-1:0] TRIG_HW = 3'd1;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/mc_mode_cmd_dec.sv
module mc_mode_cmd_dec
  import mc_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              cmd_v_o,
  output logic [CMD_W-1:0]  cmd_o
);
  logic [DATA_W-1:0] ctrl_q;

  assign cmd_v_o = we_i && (addr_i == ADDR_CTRL);
  assign cmd_o   = wdata_i[CMD_W-1:0];
  assign ctrl_o  = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (cmd_v_o) ctrl_q <= wdata_i;
  end
endmodule

// File: rtl/mc_mode_fsm.sv
module mc_mode_fsm
  import mc_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_v_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              ack_i,
  input  logic              lock_i,
  input  logic              hw_lp_i,
  output mode_e             state_o,
  output logic [TRIG_W-1:0] trig_o
);
  mode_e             state_q, state_d;
  logic [TRIG_W-1:0] trig_q, trig_d;

  always_comb begin
    state_d = state_q;
    trig_d  = trig_q;
    unique case (state_q)
      ST_INIT:    if (cmd_v_i && cmd_i == CMD_CFG) state_d = ST_CFG_REQ;
      ST_CFG: begin
        if (cmd_v_i && cmd_i == CMD_GO)        state_d = ST_ACC_REQ;
        else if (cmd_v_i && cmd_i == CMD_INIT) state_d = ST_INIT;
      end
      ST_CFG_REQ: if (ack_i) state_d = ST_CFG;
      ST_ACC_REQ: if (ack_i) state_d = ST_ACC;
      ST_ACC: begin
        // software command wins over a concurrent hardware request
        if (cmd_v_i && cmd_i == CMD_CFG) state_d = ST_CFG_REQ;
        else if (cmd_v_i && cmd_i == CMD_SLEEP) begin
          state_d = ST_LPE_REQ;
          trig_d  = TRIG_SW;
        end else if (hw_lp_i) begin
          state_d = ST_LPE_REQ;
          trig_d  = TRIG_HW;
        end
      end
      ST_LPE_REQ: if (ack_i) state_d = ST_LP;
      ST_LP: begin
        if (trig_q == TRIG_HW) begin
          if (!hw_lp_i) state_d = ST_LPX_REQ;
        end else if (cmd_v_i && cmd_i == CMD_WAKE) begin
          state_d = ST_LPX_REQ;
        end
      end
      ST_LPX_REQ: if (ack_i && lock_i) begin
        state_d = ST_ACC;
        trig_d  = TRIG_SW;
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      trig_q  <= TRIG_SW;
    end else begin
      state_q <= state_d;
      trig_q  <= trig_d;
    end
  end

  assign state_o = state_q;
  assign trig_o  = trig_q;
endmodule

// File: rtl/mc_mode_rd_mux.sv
module mc_mode_rd_mux
  import mc_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              addr_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  mode_e             state_i,
  input  logic [TRIG_W-1:0] trig_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] status;

  always_comb begin
    status = '0;
    status[STAT_W-1:0]              = state_i;
    status[TRIG_LSB +: TRIG_W]      = trig_i;
  end

  assign rdata_o = (addr_i == ADDR_STAT) ? status : ctrl_i;
endmodule

// File: rtl/mc_mode_seq.sv
module mc_mode_seq
  import mc_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              cmd_ack_i,
  input  logic              phy_dll_lock_i,
  input  logic              hw_lp_req_i,
  output logic              quiesce_req_o,
  output logic              resume_req_o,
  output logic              sr_entry_req_o,
  output logic              sr_exit_req_o,
  output logic              access_ok_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic              cmd_v;
  logic [CMD_W-1:0]  cmd;
  mode_e             state_q;
  logic [TRIG_W-1:0] trig_q;

  mc_mode_cmd_dec #(.DATA_W(DATA_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl_q),
    .cmd_v_o (cmd_v),
    .cmd_o   (cmd)
  );

  mc_mode_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_v_i (cmd_v),
    .cmd_i   (cmd),
    .ack_i   (cmd_ack_i),
    .lock_i  (phy_dll_lock_i),
    .hw_lp_i (hw_lp_req_i),
    .state_o (state_q),
    .trig_o  (trig_q)
  );

  mc_mode_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .addr_i  (reg_addr_i),
    .ctrl_i  (ctrl_q),
    .state_i (state_q),
    .trig_i  (trig_q),
    .rdata_o (reg_rdata_o)
  );

  assign quiesce_req_o  = (state_q == ST_CFG_REQ);
  assign resume_req_o   = (state_q == ST_ACC_REQ);
  assign sr_entry_req_o = (state_q == ST_LPE_REQ);
  assign sr_exit_req_o  = (state_q == ST_LPX_REQ);
  assign access_ok_o    = (state_q == ST_ACC);
endmodule

// File: rtl/mc_mode_seq_chk.sv
module mc_mode_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] state_i,
  input logic [2:0] trig_i,
  input logic       cmd_ack_i,
  input logic       phy_dll_lock_i,
  input logic       hw_lp_req_i,
  input logic       quiesce_req_o,
  input logic       resume_req_o,
  input logic       sr_entry_req_o,
  input logic       sr_exit_req_o
);
  AST_CFG_REQ_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd2 && cmd_ack_i |=> state_i == 3'd1); // R3
  AST_CFG_REQ_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd2 && $past(state_i) != 3'd2 |-> $past(state_i) == 3'd0 || $past(state_i) == 3'd3); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd2 || state_i == 3'd4 || state_i == 3'd6) && !cmd_ack_i |=> $stable(state_i)); // R5
  AST_ONE_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({quiesce_req_o, resume_req_o, sr_entry_req_o, sr_exit_req_o})); // R5
  AST_EXIT_TO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd7 && cmd_ack_i && phy_dll_lock_i |=> state_i == 3'd3 && trig_i == 3'd0); // R8
  AST_EXIT_WAITS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd7 && !(cmd_ack_i && phy_dll_lock_i) |=> state_i == 3'd7); // R9
  AST_HW_LP_NO_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd5 && trig_i == 3'd1 && hw_lp_req_i |=> state_i == 3'd5); // R10
  AST_INIT_FROM_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd0 && $past(state_i) != 3'd0 |-> $past(state_i) == 3'd1); // R12
endmodule

bind mc_mode_seq mc_mode_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .state_i        (state_q),
  .trig_i         (trig_q),
  .cmd_ack_i      (cmd_ack_i),
  .phy_dll_lock_i (phy_dll_lock_i),
  .hw_lp_req_i    (hw_lp_req_i),
  .quiesce_req_o  (quiesce_req_o),
  .resume_req_o   (resume_req_o),
  .sr_entry_req_o (sr_entry_req_o),
  .sr_exit_req_o  (sr_exit_req_o)
);

// File: tb/mc_mode_seq_bench.sv
module mc_mode_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ack = 1'b1;
  logic       lock = 1'b1;
  logic       hw = 1'b0;
  logic       q_req, r_req, e_req, x_req, acc_ok;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mc_mode_seq u_mc_mode_seq (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cmd_ack_i(ack),
    .phy_dll_lock_i(lock), .hw_lp_req_i(hw), .quiesce_req_o(q_req),
    .resume_req_o(r_req), .sr_entry_req_o(e_req), .sr_exit_req_o(x_req),
    .access_ok_o(acc_ok)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic stat(input logic [7:0] exp, input string tag);
    addr = 1'b1;
    #1;
    chk(rdata, exp, tag);
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; addr = 1'b1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; ack = 1'b1; lock = 1'b1; hw = 1'b0;
    step();
    rst_n = 1'b1;
  endtask

  // model of the command table for stable modes (software trigger)
  function automatic logic [2:0] first_of(input logic [2:0] s, input logic [2:0] c);
    case (s)
      3'd0: return (c == 3'd1) ? 3'd2 : 3'd0;
      3'd1: return (c == 3'd2) ? 3'd4 : (c == 3'd0) ? 3'd0 : 3'd1;
      3'd3: return (c == 3'd1) ? 3'd2 : (c == 3'd3) ? 3'd6 : 3'd3;
      3'd5: return (c == 3'd4) ? 3'd7 : 3'd5;
      default: return s;
    endcase
  endfunction

  function automatic logic [2:0] settle_of(input logic [2:0] s);
    case (s)
      3'd2: return 3'd1;
      3'd4: return 3'd3;
      3'd6: return 3'd5;
      3'd7: return 3'd3;
      default: return s;
    endcase
  endfunction

  task automatic goto_mode(input logic [2:0] m);
    do_reset();
    if (m != 3'd0) begin wr(1'b0, 8'd1); step(); end
    if (m == 3'd3 || m == 3'd5) begin wr(1'b0, 8'd2); step(); end
    if (m == 3'd5) begin wr(1'b0, 8'd3); step(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] modes [4];
    modes[0] = 3'd0; modes[1] = 3'd1; modes[2] = 3'd3; modes[3] = 3'd5;

    // R1 reset state
    @(negedge clk);
    step();
    rst_n = 1'b1;
    stat(8'h00, "R1 status");
    chk({7'd0, acc_ok}, 8'h00, "R1 access_ok");
    addr = 1'b0; #1; chk(rdata, 8'h00, "R1 ctrl");

    // R2 readback / R11 illegal code 5 in init / R13 status write
    wr(1'b0, 8'hA5);
    stat(8'h00, "R11 code5 ignored");
    addr = 1'b0; #1; chk(rdata, 8'hA5, "R2 ctrl readback");
    wr(1'b1, 8'h01);
    stat(8'h00, "R13 status write ignored");
    addr = 1'b0; #1; chk(rdata, 8'hA5, "R13 ctrl unchanged");

    // sweep all codes from each stable mode: R3 R4 R6 R8 R11 R12
    for (int mi = 0; mi < 4; mi++) begin
      for (int c = 0; c < 8; c++) begin
        logic [2:0] f;
        goto_mode(modes[mi]);
        wr(1'b0, 8'(c));
        f = first_of(modes[mi], 3'(c));
        stat({5'd0, f}, $sformatf("R11 sweep first mode%0d cmd%0d", modes[mi], c));
        step();
        stat({5'd0, settle_of(f)}, $sformatf("R5 sweep settle mode%0d cmd%0d", modes[mi], c));
      end
    end

    // R5 hold without ack, R3 handshake
    goto_mode(3'd0);
    ack = 1'b0;
    wr(1'b0, 8'd1);
    chk({7'd0, q_req}, 8'h01, "R3 quiesce_req");
    step(); step(); step();
    stat(8'h02, "R5 held in config_req");
    ack = 1'b1;
    step();
    stat(8'h01, "R3 config reached");
    wr(1'b0, 8'd2);
    chk({7'd0, r_req}, 8'h01, "R4 resume_req");
    wr(1'b0, 8'd1);
    stat(8'h03, "R11 cmd in access_req ignored");
    chk({7'd0, acc_ok}, 8'h01, "R4 access_ok");

    // R9 lock gating of exit
    goto_mode(3'd5);
    lock = 1'b0;
    wr(1'b0, 8'd4);
    chk({7'd0, x_req}, 8'h01, "R8 sr_exit_req");
    step(); step();
    stat(8'h07, "R9 waits for lock");
    lock = 1'b1; ack = 1'b0;
    step();
    stat(8'h07, "R9 waits for ack");
    ack = 1'b1;
    step();
    stat(8'h03, "R8 exit lands in access");

    // R7 / R10 hardware trigger
    goto_mode(3'd3);
    hw = 1'b1;
    step();
    stat(8'h16, "R7 hw entry req");
    chk({7'd0, e_req}, 8'h01, "R6 sr_entry_req");
    step();
    stat(8'h15, "R7 hw low_power");
    wr(1'b0, 8'd4);
    stat(8'h15, "R10 wakeup ignored");
    hw = 1'b0;
    step();
    stat(8'h17, "R7 hw exit req");
    step();
    stat(8'h03, "R8 trig cleared in access");

    // R6 software priority over hw in same cycle
    hw = 1'b1;
    wr(1'b0, 8'd3);
    stat(8'h06, "R6 sw sleep trigger 0");
    hw = 1'b0;
    step();
    stat(8'h05, "R6 low_power");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule